// File: doc/BRIEF.md
# Three-Channel Register-Mapped Watchdog Timer

This peripheral holds three independent watchdog channels. They all advance on a shared single-cycle reference tick. Each channel has a 32-bit elapsed-time counter that counts up from zero and that software may overwrite with any value. Each channel also has a fire threshold and a control word. When the reset-enable bit of a channel is set and its counter is at or above its fire threshold, the channel latches a reset request. Channel 0 drives a recovery-reset output. Channels 1 and 2 share a normal-reset output.

Channel 0 also has a warning threshold. When its interrupt-enable bit is set and its counter is at or above that threshold, a status bit is set and the interrupt output goes high. Software clears the status bit by writing one to it. Keepalive is done by writing zero to the counter. Software stops a channel by clearing its reset-enable bit. Software forces an immediate reset by writing zero to both the threshold and the counter with reset enabled.

Each channel carries a three-state sequencer with these states:
- `CH_IDLE`: reset disabled.
- `CH_ARMED`: reset enabled, threshold not reached.
- `CH_FIRED`: reset request latched.

Its transitions are:
- enable (IDLE→ARMED)
- disable (ARMED→IDLE)
- expire (IDLE/ARMED→FIRED, taken when enable is set and the counter is at or above the threshold)
- hold (FIRED→FIRED, left only by the system reset)

Top module: `multi_wdog`

## Requirements
- R1: Every cycle with `ref_tick` high, each channel's counter increments by one, wrapping from 0xFFFFFFFF to 0.
- R2: A write to a channel's counter loads the written value at the next edge, and the write takes precedence over a tick in the same cycle. A write to one channel's counter does not stop the other channels from counting.
- R3: Channel 0 asserts `recov_rst` one edge after its control bit 2 (reset enable) is set and its counter is >= its fire threshold (unsigned). Channel 0 never drives `sys_rst`.
- R4: Channels 1 and 2 each assert `sys_rst` under the same condition, using their own counters, thresholds and control bit 2.
- R5: Channel 0 sets its status bit (control bit 1) one edge after control bit 0 (interrupt enable) is set and its counter is >= its warning threshold. `irq` equals that status bit.
- R6: A control write with bit 1 = 1 clears the status bit, and a write with bit 1 = 0 leaves it unchanged. If the set condition holds in the same cycle as the clear, the set wins.
- R7: A reset output, once asserted, stays high until `rst_n` is asserted, even if reset enable is later cleared. A channel whose reset enable is clear never fires.
- R8: The address map is as follows:
  - Channel base = 0x10 × channel (0x00, 0x10, 0x20).
  - Offsets within a channel: +0x0 counter, +0x4 fire threshold, +0x8 warning threshold (channel 0 only), +0xC control.
  - A read returns the register value on `rdata` one edge after `rd_en`, and `rdata` holds between reads.
  - Unimplemented offsets (e.g. 0x18, 0x28, 0x30–0x3C) and addresses with `addr[1:0]` ≠ 0 read 0 and ignore writes.
  - Channels 1 and 2 read control bits 0 and 1 as 0.
- R9: After reset, every register reads 0 except the three fire thresholds, which read 0xFFFFFFFF, and all outputs are low.
- R10: Counters run whatever the enable bits are set to; the enables gate only the outputs.
- R11: With reset enabled, writing 0 to the fire threshold and then 0 to the counter causes a reset at once, since 0 >= 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ref_tick | input | 1 | One-cycle reference tick, advances all counters |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one edge after `rd_en` |
| irq | output | 1 | Channel 0 warning interrupt (status bit) |
| recov_rst | output | 1 | Latched recovery-reset request from channel 0 |
| sys_rst | output | 1 | Latched normal-reset request from channel 1 or 2 |

## Verification
- **Register writes and reads.** A register write takes effect at the edge that samples it. A read returns the values from before that same edge, so `rdata` carries the old value one edge after `rd_en`.
- **Comparison outputs.** `irq`, `recov_rst` and `sys_rst` are evaluated from the register contents, so they change one edge after the registers meet the condition. That is two edges after the write that completes it.
- **Bench timing.** The bench drives all inputs at the falling edge. A behavioural model computes the next state from the values before the edge, applies writes and ticks, and updates the expected read data. Every output is compared 1 ns after each rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    // register field selected by addr[3:2]
    typedef enum logic [1:0] {
        FLD_TIME  = 2'd0,
        FLD_FIRE  = 2'd1,
        FLD_WARN  = 2'd2,
        FLD_CTRL  = 2'd3
    } wdg_field_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_FIRED = 2'd2
    } ch_state_e;

    // control word bit positions
    localparam int CTL_IRQ_EN = 0;
    localparam int CTL_IRQ_ST = 1;
    localparam int CTL_RST_EN = 2;
    localparam int CTL_W      = 3;
endpackage

// File: rtl/wdg_addr_dec.sv
module wdg_addr_dec
    import wdg_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 6,
    parameter int WARN_CH = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_sel,
    output wdg_field_e        field
);
    localparam int CH_LSB = 4;
    localparam int CH_W   = ADDR_W - CH_LSB;

    logic [CH_W-1:0] ch_idx;
    logic            aligned;

    assign ch_idx  = addr[ADDR_W-1:CH_LSB];
    assign aligned = (addr[1:0] == 2'b00);
    assign field   = wdg_field_e'(addr[3:2]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        // warning threshold exists only on the warning channel
        assign ch_sel[i] = aligned && (ch_idx == CH_W'(i)) &&
                           ((field != FLD_WARN) || (i == WARN_CH));
    end

    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(ch_sel)); // R8
    end
endmodule

// File: rtl/wdg_channel.sv
module wdg_channel
    import wdg_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter bit HAS_WARN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             wr_time,
    input  logic             wr_fire,
    input  logic             wr_warn,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] time_o,
    output logic [CNT_W-1:0] fire_lim_o,
    output logic [CNT_W-1:0] warn_lim_o,
    output logic [CTL_W-1:0] ctrl_o,
    output logic             fire_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] time_q;
    logic [CNT_W-1:0] fire_lim_q;
    logic             rst_en_q;
    logic             expired;
    ch_state_e        state_q;
    ch_state_e        state_d;

    // elapsed-time counter: a write wins over a tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (wr_time) begin
            time_q <= wdata;
        end else if (ref_tick) begin
            time_q <= time_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_lim_q <= '1;
            rst_en_q   <= 1'b0;
        end else begin
            if (wr_fire) begin
                fire_lim_q <= wdata;
            end
            if (wr_ctrl) begin
                rst_en_q <= wdata[CTL_RST_EN];
            end
        end
    end

    assign expired = rst_en_q && (time_q >= fire_lim_q);

    // sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (expired)       state_d = CH_FIRED;
                else if (rst_en_q) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (expired)        state_d = CH_FIRED;
                else if (!rst_en_q) state_d = CH_IDLE;
            end
            CH_FIRED: state_d = CH_FIRED;
            default:  state_d = CH_IDLE;
        endcase
    end

    // sequencer: outputs
    always_comb begin
        fire_o = (state_q == CH_FIRED);
    end

    assign time_o     = time_q;
    assign fire_lim_o = fire_lim_q;

    generate
        if (HAS_WARN) begin : g_warn
            logic [CNT_W-1:0] warn_lim_q;
            logic             irq_en_q;
            logic             irq_st_q;
            logic             warn_hit;
            logic             clr_req;

            assign warn_hit = irq_en_q && (time_q >= warn_lim_q);
            assign clr_req  = wr_ctrl && wdata[CTL_IRQ_ST];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    warn_lim_q <= '0;
                    irq_en_q   <= 1'b0;
                    irq_st_q   <= 1'b0;
                end else begin
                    if (wr_warn) begin
                        warn_lim_q <= wdata;
                    end
                    if (wr_ctrl) begin
                        irq_en_q <= wdata[CTL_IRQ_EN];
                    end
                    irq_st_q <= (irq_st_q && !clr_req) || warn_hit;
                end
            end

            assign warn_lim_o = warn_lim_q;
            assign irq_o      = irq_st_q;
            assign ctrl_o     = {rst_en_q, irq_st_q, irq_en_q};

            AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
                warn_hit |=> irq_o); // R5
            AST_WARN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_req && !warn_hit) |=> !irq_o); // R6
            AST_WARN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_o && !clr_req) |=> irq_o); // R6
        end else begin : g_nowarn
            logic unused_warn;
            assign unused_warn = wr_warn;
            assign warn_lim_o  = '0;
            assign irq_o       = 1'b0;
            assign ctrl_o      = {rst_en_q, 2'b00};
        end
    endgenerate

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && !wr_time) |=> time_q == $past(time_q) + CNT_W'(1)); // R1
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time |=> time_q == $past(wdata)); // R2
    AST_FIRE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_en_q && time_q >= fire_lim_q) |=> fire_o); // R3
    AST_FIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> fire_o); // R7
    AST_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_o && !rst_en_q) |=> !fire_o); // R7
endmodule

// File: rtl/multi_wdog.sv
module multi_wdog
    import wdg_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int RECOV_CH = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              recov_rst,
    output logic              sys_rst
);
    logic [NUM_CH-1:0] ch_sel;
    wdg_field_e        field;
    logic [CNT_W-1:0]  time_v  [NUM_CH];
    logic [CNT_W-1:0]  fire_v  [NUM_CH];
    logic [CNT_W-1:0]  warn_v  [NUM_CH];
    logic [CTL_W-1:0]  ctrl_v  [NUM_CH];
    logic [NUM_CH-1:0] fire_vec;
    logic [NUM_CH-1:0] irq_vec;
    logic [NUM_CH-1:0] norm_vec;
    logic [DATA_W-1:0] rd_mux;

    wdg_addr_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .WARN_CH(RECOV_CH)
    ) u_dec (
        .addr  (addr),
        .ch_sel(ch_sel),
        .field (field)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        wdg_channel #(
            .CNT_W   (CNT_W),
            .HAS_WARN(i == RECOV_CH)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ref_tick  (ref_tick),
            .wr_time   (wr_en && ch_sel[i] && (field == FLD_TIME)),
            .wr_fire   (wr_en && ch_sel[i] && (field == FLD_FIRE)),
            .wr_warn   (wr_en && ch_sel[i] && (field == FLD_WARN)),
            .wr_ctrl   (wr_en && ch_sel[i] && (field == FLD_CTRL)),
            .wdata     (wdata[CNT_W-1:0]),
            .time_o    (time_v[i]),
            .fire_lim_o(fire_v[i]),
            .warn_lim_o(warn_v[i]),
            .ctrl_o    (ctrl_v[i]),
            .fire_o    (fire_vec[i]),
            .irq_o     (irq_vec[i])
        );
        assign norm_vec[i] = (i != RECOV_CH) && fire_vec[i];
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) begin
                unique case (field)
                    FLD_TIME: rd_mux = DATA_W'(time_v[i]);
                    FLD_FIRE: rd_mux = DATA_W'(fire_v[i]);
                    FLD_WARN: rd_mux = DATA_W'(warn_v[i]);
                    FLD_CTRL: rd_mux = DATA_W'(ctrl_v[i]);
                    default:  rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    assign irq       = |irq_vec;
    assign recov_rst = fire_vec[RECOV_CH];
    assign sys_rst   = |norm_vec;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R8
    AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> sys_rst); // R7
endmodule

// File: tb/tb_multi_wdog.sv
module tb_multi_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, recov_rst, sys_rst;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string req = "R9";

    // behavioural reference model
    logic [31:0] m_time [3];
    logic [31:0] m_fire [3];
    logic [31:0] m_warn;
    bit          m_ren  [3];
    bit          m_fired[3];
    bit          m_ien, m_ist;
    logic [31:0] m_rdata;

    always #5 clk = ~clk;

    multi_wdog dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .recov_rst(recov_rst), .sys_rst(sys_rst)
    );

    task automatic m_reset();
        for (int i = 0; i < 3; i++) begin
            m_time[i] = 0; m_fire[i] = 32'hFFFF_FFFF; m_ren[i] = 0; m_fired[i] = 0;
        end
        m_warn = 0; m_ien = 0; m_ist = 0; m_rdata = 0;
    endtask

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int c = a[5:4];
        int f = a[3:2];
        if (a[1:0] != 0 || c > 2) return 0;
        case (f)
            0: return m_time[c];
            1: return m_fire[c];
            2: return (c == 0) ? m_warn : 32'd0;
            default: return (c == 0) ? {29'd0, m_ren[0], m_ist, m_ien} : {29'd0, m_ren[c], 2'b00};
        endcase
    endfunction

    task automatic m_edge();
        bit nf[3];
        bit nst;
        int c = addr[5:4];
        int f = addr[3:2];
        bit ok = (addr[1:0] == 0) && (c <= 2);
        bit wt[3];
        for (int i = 0; i < 3; i++) begin
            nf[i] = m_fired[i] || (m_ren[i] && m_time[i] >= m_fire[i]);
            wt[i] = 0;
        end
        nst = (m_ist && !(wr_en && ok && c == 0 && f == 3 && wdata[1])) ||
              (m_ien && m_time[0] >= m_warn);
        if (rd_en) m_rdata = m_read(addr);
        if (wr_en && ok) begin
            case (f)
                0: begin m_time[c] = wdata; wt[c] = 1; end
                1: m_fire[c] = wdata;
                2: if (c == 0) m_warn = wdata;
                default: begin
                    m_ren[c] = wdata[2];
                    if (c == 0) m_ien = wdata[0];
                end
            endcase
        end
        for (int i = 0; i < 3; i++) begin
            if (!wt[i] && ref_tick) m_time[i] = m_time[i] + 1;
            m_fired[i] = nf[i];
        end
        m_ist = nst;
    endtask

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit rs, input bit tk, input bit we, input bit re,
                        input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        rst_n = ~rs; ref_tick = tk; wr_en = we; rd_en = re; addr = a; wdata = d;
        @(posedge clk);
        if (rs) m_reset(); else m_edge();
        #1;
        n_vec++;
        cmp("rdata", rdata, m_rdata);
        cmp("irq", {31'd0, irq}, {31'd0, m_ist});
        cmp("recov_rst", {31'd0, recov_rst}, {31'd0, m_fired[0]});
        cmp("sys_rst", {31'd0, sys_rst}, {31'd0, m_fired[1] | m_fired[2]});
    endtask

    task automatic idle(input int n, input bit tk);
        for (int i = 0; i < n; i++) step(0, tk, 0, 0, 0, 0);
    endtask
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(0, 0, 1, 0, a, d);
    endtask
    task automatic rd(input logic [5:0] a);
        step(0, 0, 0, 1, a, 0);
    endtask
    task automatic do_reset();
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        m_reset();
        do_reset();

        // R9: reset values, R8: full map including holes
        req = "R9";
        for (int a = 0; a < 64; a += 4) rd(6'(a));
        req = "R8";
        rd(6'h05); rd(6'h18); rd(6'h28);

        // R1 / R10: counters run with every enable clear
        req = "R10";
        idle(7, 1);
        rd(6'h00); rd(6'h10); rd(6'h20);

        // R2: write beats a tick; other channels keep counting
        req = "R2";
        step(0, 1, 1, 0, 6'h10, 32'h0000_1234);
        step(0, 1, 0, 1, 6'h10, 0);
        rd(6'h00); rd(6'h10);
        wr(6'h13, 32'hDEAD_BEEF);   // unaligned write ignored (R8)
        rd(6'h10);

        // R1: wrap-around
        req = "R1";
        wr(6'h20, 32'hFFFF_FFFE);
        idle(3, 1);
        rd(6'h20);

        // R8: channel 1 control only keeps bit 2
        req = "R8";
        wr(6'h1C, 32'h7); rd(6'h1C);
        wr(6'h1C, 32'h0); rd(6'h1C);
        wr(6'h18, 32'h55); rd(6'h18);

        // R5 / R6: warning interrupt, set-wins and write-one-to-clear
        req = "R5";
        wr(6'h08, 32'd5); wr(6'h00, 0); wr(6'h0C, 32'h1);
        idle(8, 1);
        rd(6'h0C);
        req = "R6";
        wr(6'h0C, 32'h1);            // bit1 = 0 leaves status
        idle(2, 0);
        wr(6'h0C, 32'h2);            // clear while set condition live: set wins
        idle(2, 0);
        wr(6'h0C, 32'h2);            // enable now clear: status cleared
        idle(2, 1);
        rd(6'h0C);

        // R4 / R7: channel 1 with keepalive, then expiry, then sticky
        req = "R4";
        wr(6'h14, 32'd10); wr(6'h10, 0); wr(6'h1C, 32'h4);
        for (int k = 0; k < 4; k++) begin
            idle(6, 1);
            wr(6'h10, 0);
        end
        idle(14, 1);
        req = "R7";
        wr(6'h1C, 32'h0);
        idle(5, 1);
        do_reset();

        // R11: immediate reset on channel 2
        req = "R11";
        wr(6'h2C, 32'h4); wr(6'h24, 0); wr(6'h20, 0);
        idle(3, 0);
        do_reset();

        // R3: channel 0 recovery path, sys_rst stays low
        req = "R3";
        wr(6'h04, 32'd3); wr(6'h00, 0); wr(6'h0C, 32'h4);
        idle(6, 1);
        do_reset();

        // R7: disabling before expiry prevents any reset
        req = "R7";
        wr(6'h24, 32'd5); wr(6'h20, 0); wr(6'h2C, 32'h4);
        idle(2, 1);
        wr(6'h2C, 32'h0);
        idle(10, 1);
        rd(6'h2C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule